// File: doc/BRIEF.md
# Translation Lookaside Cache with Age-Ordered Replacement

This block sits between an address generator and the page/segment mapping table held in main memory. It keeps a small set of recently used (block number, block base) pairs. A lookup compares the presented block number against every stored pair in the same cycle. On a match, the base is returned at once and memory is not touched.

On a miss, the block issues a single read of the mapping table for that block number over a request/acknowledge interface. A defined answer is written into the cache and returned to the requester. An answer marked undefined is reported as a fault and is not kept. While a miss is outstanding, no further lookup is accepted.

Recency is kept as a per-entry age that forms a permutation of 0..ENTRIES-1. An empty slot is always filled before any live entry is displaced. When every slot is live, the entry with the greatest age is displaced. A flush input empties the whole cache in one cycle; it is meant for the moment the running program's mapping table is switched.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `lookup_ready` is 1, `done` and `walk_req` are 0, and no entry is valid, so the first lookup of any key misses.
- R2: A lookup of a resident key accepted in cycle C (`lookup_valid` and `lookup_ready` both 1) gives `done`=1, `hit`=1 and the stored base on `base_out` in cycle C+1. `walk_req` stays 0.
- R3: A lookup that misses in cycle C raises `walk_req` for exactly cycle C+1, with `walk_key` equal to the looked-up key. `done` is 0 in C+1.
- R4: An acknowledge with `walk_defined`=1 in cycle W (W ≥ C+2) gives `done`=1, `hit`=0, `fault`=0 and `base_out` = `walk_base` in cycle W+2. `done` is 0 in W+1. An acknowledge in cycle C+1 is not taken.
- R5: A key filled under R4 hits under R2 on its next lookup.
- R6: Empty slots are used before any valid entry is displaced, so ENTRIES distinct fills after a flush all remain resident.
- R7: When all slots are valid, a fill displaces the least recently used entry. Both hits and fills count as uses.
- R8: An acknowledge with `walk_defined`=0 in cycle W gives `done`=1, `fault`=1, `hit`=0 in cycle W+1, and the key is not installed.
- R9: A one-cycle `flush` invalidates every entry.
- R10: A lookup accepted in the same cycle as `flush` is treated as a miss. A `flush` in the cycle before a fill's result still lets that result be returned, but the filled key is not kept.
- R11: `lookup_ready` is 0 from acceptance of a miss until its result. `lookup_valid` in that window starts no lookup and no table request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lookup_valid | input | 1 | Lookup request |
| lookup_key | input | IDX_W | Block number to translate |
| lookup_ready | output | 1 | Lookup can be accepted this cycle |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Result came from the cache |
| fault | output | 1 | Table entry was undefined |
| base_out | output | BASE_W | Base of the block (0 on fault) |
| walk_req | output | 1 | Mapping table read request (one cycle) |
| walk_key | output | IDX_W | Block number to read from the table |
| walk_ack | input | 1 | Table response valid |
| walk_defined | input | 1 | Table entry is defined |
| walk_base | input | BASE_W | Base from the table |

## Verification
Two cases can fall in the same cycle. In the first, `flush` coincides with a lookup, and the outcome must be a miss with a table request. In the second, `flush` lands in the cycle when a fetched entry is written. Here the fetched base must still come out, but a later lookup of that key must miss again. The bench drives `flush` on the same falling edge as the lookup strobe, and again on the falling edge that opens the write cycle. It then judges both outcomes only at the ports: by whether `walk_req` rises and what `done`/`hit` report.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_REQ  = 2'd1,
      WK_WAIT = 2'd2,
      WK_FILL = 2'd3
   } walk_st_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 12,
   localparam int SEL_W  = $clog2(ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ENTRIES-1:0]  vld,
   input  logic [IDX_W-1:0]    keys [ENTRIES],
   input  logic [IDX_W-1:0]    probe,
   input  logic                block,
   output logic                any_hit,
   output logic [SEL_W-1:0]    hit_sel
);
   logic [ENTRIES-1:0] hit_vec;

   // one comparator per slot, all in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (keys[g] == probe) && !block;
   end

   assign any_hit = |hit_vec;

   always_comb begin
      hit_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) hit_sel = hit_sel | SEL_W'(i);
      end
   end

   // R2: a key is never resident twice
   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
   parameter int ENTRIES = 16,
   localparam int SEL_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] vld,
   input  logic               touch,
   input  logic [SEL_W-1:0]   touch_sel,
   output logic [SEL_W-1:0]   victim_sel
);
   localparam logic [SEL_W-1:0] OLDEST = SEL_W'(ENTRIES - 1);

   logic [SEL_W-1:0] age_q [ENTRIES];
   logic [SEL_W-1:0] ref_age;

   assign ref_age = age_q[touch_sel];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[g] <= SEL_W'(g);
         end else if (touch) begin
            if (touch_sel == SEL_W'(g))  age_q[g] <= '0;
            else if (age_q[g] < ref_age) age_q[g] <= age_q[g] + 1'b1;
         end
      end
   end

   // lowest empty slot first, otherwise the oldest live slot
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            victim_sel = SEL_W'(i);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == OLDEST) victim_sel = SEL_W'(i);
         end
      end
   end

   logic [ENTRIES-1:0] youngest;
   always_comb begin
      for (int i = 0; i < ENTRIES; i++) youngest[i] = (age_q[i] == '0);
   end

   // R7: ages stay a permutation, exactly one youngest slot
   a_r7_one_youngest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(youngest) == 1);
   // R7: a used slot becomes the youngest
   a_r7_touch_young: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> age_q[$past(touch_sel)] == '0);
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
   import xlat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic miss_go,
   input  logic walk_ack,
   input  logic walk_defined,
   output logic idle,
   output logic walk_req,
   output logic take_rsp,
   output logic fill_go,
   output logic fault_go
);
   walk_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         WK_IDLE: if (miss_go) st_d = WK_REQ;
         WK_REQ:  st_d = WK_WAIT;
         WK_WAIT: if (walk_ack) st_d = walk_defined ? WK_FILL : WK_IDLE;
         WK_FILL: st_d = WK_IDLE;
         default: st_d = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WK_IDLE;
      else        st_q <= st_d;
   end

   assign idle     = (st_q == WK_IDLE);
   assign walk_req = (st_q == WK_REQ);
   assign take_rsp = (st_q == WK_WAIT) && walk_ack && walk_defined;
   assign fault_go = (st_q == WK_WAIT) && walk_ack && !walk_defined;
   assign fill_go  = (st_q == WK_FILL);

   // R3: the table request lasts one cycle
   a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |=> !walk_req);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 12,
   parameter int BASE_W  = 16,
   localparam int SEL_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lookup_valid,
   input  logic [IDX_W-1:0]  lookup_key,
   output logic              lookup_ready,
   output logic              done,
   output logic              hit,
   output logic              fault,
   output logic [BASE_W-1:0] base_out,
   output logic              walk_req,
   output logic [IDX_W-1:0]  walk_key,
   input  logic              walk_ack,
   input  logic              walk_defined,
   input  logic [BASE_W-1:0] walk_base
);
   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must lie in 2..64");
   end
   if (IDX_W < 1 || BASE_W < 1) begin : g_bad_width
      $error("xlat_cache: IDX_W and BASE_W must be positive");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [IDX_W-1:0]   key_q  [ENTRIES];
   logic [BASE_W-1:0]  base_q [ENTRIES];
   logic [IDX_W-1:0]   pend_key_q;
   logic [BASE_W-1:0]  pend_base_q;

   logic             idle, take_rsp, fill_go, fault_go;
   logic             any_hit, accept, hit_now, miss_now, keep_fill;
   logic [SEL_W-1:0] hit_sel, victim_sel, touch_sel;

   assign lookup_ready = idle;
   assign accept       = lookup_valid && idle;
   assign hit_now      = accept && any_hit;
   assign miss_now     = accept && !any_hit;
   assign keep_fill    = fill_go && !flush;
   assign touch_sel    = hit_now ? hit_sel : victim_sel;
   assign walk_key     = pend_key_q;

   xlat_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
      .clk(clk), .rst_n(rst_n), .vld(vld_q), .keys(key_q),
      .probe(lookup_key), .block(flush),
      .any_hit(any_hit), .hit_sel(hit_sel));

   xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .vld(vld_q),
      .touch(hit_now || keep_fill), .touch_sel(touch_sel),
      .victim_sel(victim_sel));

   xlat_walk u_walk (
      .clk(clk), .rst_n(rst_n), .miss_go(miss_now),
      .walk_ack(walk_ack), .walk_defined(walk_defined),
      .idle(idle), .walk_req(walk_req), .take_rsp(take_rsp),
      .fill_go(fill_go), .fault_go(fault_go));

   // slot storage
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            key_q[g]  <= '0;
            base_q[g] <= '0;
         end else if (flush) begin
            vld_q[g]  <= 1'b0;
         end else if (fill_go && victim_sel == SEL_W'(g)) begin
            vld_q[g]  <= 1'b1;
            key_q[g]  <= pend_key_q;
            base_q[g] <= pend_base_q;
         end
      end
   end

   // pending miss
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_key_q  <= '0;
         pend_base_q <= '0;
      end else begin
         if (miss_now) pend_key_q  <= lookup_key;
         if (take_rsp) pend_base_q <= walk_base;
      end
   end

   // result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         hit      <= 1'b0;
         fault    <= 1'b0;
         base_out <= '0;
      end else begin
         done  <= hit_now || fill_go || fault_go;
         hit   <= hit_now;
         fault <= fault_go;
         if (hit_now)      base_out <= base_q[hit_sel];
         else if (fill_go) base_out <= pend_base_q;
         else              base_out <= '0;
      end
   end

   // R2: a hit answers next cycle without the table
   a_r2_hit_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && lookup_ready && any_hit) |=> (done && hit && !walk_req));
   // R8: fault and hit never together
   a_r8_fault_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && !hit));
   // R9: flush empties every slot
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
   // R11: no lookup taken while the table read is outstanding
   a_r11_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !lookup_ready);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   localparam int ENTRIES = 16;
   localparam int IDX_W   = 12;
   localparam int BASE_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              lookup_valid = 1'b0;
   logic [IDX_W-1:0]  lookup_key = '0;
   logic              lookup_ready, done, hit, fault, walk_req;
   logic [BASE_W-1:0] base_out;
   logic [IDX_W-1:0]  walk_key;
   logic              walk_ack = 1'b0;
   logic              walk_defined = 1'b0;
   logic [BASE_W-1:0] walk_base = '0;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   xlat_cache #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .BASE_W(BASE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lookup_valid(lookup_valid), .lookup_key(lookup_key),
      .lookup_ready(lookup_ready), .done(done), .hit(hit), .fault(fault),
      .base_out(base_out), .walk_req(walk_req), .walk_key(walk_key),
      .walk_ack(walk_ack), .walk_defined(walk_defined), .walk_base(walk_base));

   function automatic logic [BASE_W-1:0] table_base(input logic [IDX_W-1:0] k);
      return {k[3:0], k} ^ 16'h3C5A;
   endfunction
   function automatic logic table_ok(input logic [IDX_W-1:0] k);
      return k[11:8] != 4'hF;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one lookup with optional table walk
   task automatic access(input logic [IDX_W-1:0] key, input logic exp_hit,
                         input string req, input logic flush_same = 1'b0,
                         input logic flush_fill = 1'b0, input logic poke = 1'b0);
      @(negedge clk);
      lookup_valid = 1'b1; lookup_key = key; flush = flush_same;
      @(negedge clk);
      lookup_valid = 1'b0; flush = 1'b0;
      if (exp_hit) begin
         chk({req, " hit done"}, done, 1);
         chk({req, " hit flag"}, hit, 1);
         chk({req, " hit base"}, base_out, table_base(key));
         chk({req, " hit no walk"}, walk_req, 0);
         return;
      end
      chk({req, " R3 walk_req"}, walk_req, 1);
      chk({req, " R3 walk_key"}, walk_key, key);
      chk({req, " R3 no done"}, done, 0);
      chk({req, " R11 busy"}, lookup_ready, 0);
      @(negedge clk);
      chk({req, " R3 req pulse"}, walk_req, 0);
      if (poke) begin
         lookup_valid = 1'b1; lookup_key = key ^ 12'h001;
      end
      @(negedge clk);
      walk_ack = 1'b1; walk_defined = table_ok(key); walk_base = table_base(key);
      @(negedge clk);
      walk_ack = 1'b0; lookup_valid = 1'b0;
      if (!table_ok(key)) begin
         chk({req, " R8 done"}, done, 1);
         chk({req, " R8 fault"}, fault, 1);
         chk({req, " R8 hit"}, hit, 0);
         return;
      end
      chk({req, " R4 early done"}, done, 0);
      if (poke) chk({req, " R11 busy fill"}, lookup_ready, 0);
      flush = flush_fill;
      @(negedge clk);
      flush = 1'b0;
      chk({req, " R4 done"}, done, 1);
      chk({req, " R4 hit"}, hit, 0);
      chk({req, " R4 fault"}, fault, 0);
      chk({req, " R4 base"}, base_out, table_base(key));
      if (poke) begin
         @(negedge clk);
         chk({req, " R11 no extra done"}, done, 0);
         chk({req, " R11 no extra walk"}, walk_req, 0);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 ready", lookup_ready, 1);
      chk("R1 done", done, 0);
      chk("R1 walk_req", walk_req, 0);
      access(12'h010, 1'b0, "R1 first miss");
   endtask

   task automatic t_fill_hit();
      access(12'h010, 1'b1, "R5 R2 refetch");
      access(12'h011, 1'b0, "R4 second");
      access(12'h011, 1'b1, "R5 R2 second");
   endtask

   task automatic t_capacity_lru();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      for (int i = 0; i < ENTRIES; i++) access(IDX_W'(12'h100 + i), 1'b0, "R6 fill");
      for (int i = 0; i < ENTRIES; i++) access(IDX_W'(12'h100 + i), 1'b1, "R6 resident");
      access(12'h100, 1'b1, "R7 reuse");
      access(12'h200, 1'b0, "R7 new");
      access(12'h100, 1'b1, "R7 kept recent");
      access(12'h102, 1'b1, "R7 kept other");
      access(12'h101, 1'b0, "R7 evicted");
   endtask

   task automatic t_fault();
      access(12'hF12, 1'b0, "R8 first");
      access(12'hF12, 1'b0, "R8 not kept");
   endtask

   task automatic t_flush();
      access(12'h100, 1'b1, "R9 before");
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      access(12'h100, 1'b0, "R9 after");
      access(12'h200, 1'b0, "R9 other gone");
   endtask

   task automatic t_concurrent();
      access(12'h100, 1'b1, "R10 resident");
      access(12'h100, 1'b0, "R10 flush with lookup", 1'b1);
      access(12'h300, 1'b0, "R10 flush in fill", 1'b0, 1'b1);
      access(12'h300, 1'b0, "R10 fill dropped");
      access(12'h300, 1'b1, "R10 refill kept");
   endtask

   task automatic t_busy();
      access(12'h040, 1'b0, "R11 poke", 1'b0, 1'b0, 1'b1);
      access(12'h041, 1'b0, "R11 poked key absent");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_hit();
      t_capacity_lru();
      t_fault();
      t_flush();
      t_concurrent();
      t_busy();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule